// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block resolves one virtual-to-physical translation by walking page tables held in ordinary memory. A request carries a 32-bit virtual address, a 4-bit context number, the current context-table pointer, the kind of access and whether it comes from user or supervisor mode. The walker fetches the context-table entry, then follows descriptors through a region table, a segment table and a page table. It stops at the first page-table entry (PTE) it meets, or at the first entry that cannot be followed.

When a PTE is reached, the walker checks the access against the entry's 3-bit permission code. If the access is allowed, it marks the entry as referenced (and as modified for stores) by writing it back. It then returns a 36-bit physical address and a cacheable flag. A walk that cannot complete returns a fault code that names the table level, or a protection fault.

All table reads and the write-back use one memory port. The port has a valid/ready request channel and a response channel, and at most one transaction is in flight at a time. The block serves one walk at a time.

Top module: `mmu_tablewalk`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0 and `mem_req_valid` is 0.
- R2: The context entry is read at byte address `{req_ctp[31:2],6'b0} + 4*req_ctx`. A descriptor's child table has base `{desc[31:2],6'b0}`, and the child entry is read at base + 4*index. The index is va[31:24] for the region table (256 entries), va[23:18] for the segment table (64 entries) and va[17:12] for the page table (64 entries).
- R3: Bits 1:0 of every entry give its type: 0 invalid, 1 descriptor, 2 PTE, 3 reserved. An invalid or reserved entry ends the walk with `res_fault` = 1 + level, where the context level is 0, region 1, segment 2 and page 3.
- R4: A PTE found in the context table gives fault 1. A descriptor found in the page table gives fault 4.
- R5: A PTE ends the walk at the region, segment or page level. The physical address takes PTE[31:8] as PA[35:12]. The low 24, 18 or 12 bits (region, segment or page level) are then replaced by the same bits of the virtual address. `res_fault` is 0.
- R6: On a successful walk, `res_cacheable` equals PTE bit 7.
- R7: For user accesses (`req_user`=1), PTE[4:2] grants: 0 read; 1 read/write; 2 read/execute; 3 all; 4 execute only; 5 read; 6 and 7 nothing. A denied access gives `res_fault` = 5.
- R8: For supervisor accesses, PTE[4:2] grants: 0 read; 1 read/write; 2 read/execute; 3 all; 4 execute only; 5 read/write; 6 read/execute; 7 all. `req_acc` is 0 load (needs read), 1 store (needs write), 2 fetch (needs execute); 3 is treated as a load.
- R9: On an allowed access, the walker writes the PTE back to the address it was read from, with bit 5 (referenced) set, and with bit 6 (modified) also set for a store. The write is issued only when this changes the entry.
- R10: A faulting walk reports `res_pa` = 0 and `res_cacheable` = 0, and performs no memory write.
- R11: A memory request is held stable until accepted. No new request is issued while a response is outstanding.
- R12: Each accepted request produces exactly one single-cycle `res_valid` pulse. `req_ready` is high only while no walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_va | input | 32 | Virtual address |
| req_ctx | input | 4 | Context number |
| req_ctp | input | 32 | Context-table pointer value |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for the PTE write-back |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_req_wdata | output | 32 | Updated PTE for write-back |
| mem_rsp_valid | input | 1 | Read data or write completion |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Result pulse |
| res_pa | output | 36 | Physical address |
| res_cacheable | output | 1 | Cacheable flag from the PTE |
| res_fault | output | 3 | 0 ok, 1..4 bad entry at level, 5 protection |

## Verification
The embedded assertions are checked on every cycle. They cover:
- request stability and the single outstanding transaction on the memory port;
- the referenced bit and PTE type in every write-back;
- the zero address and flag on faults;
- user denial of codes 6 and 7;
- the single-cycle result pulse.

Other behaviours can be shown only by the bench's scenarios against its table image. These are:
- the index fields and table bases used at each level;
- the fault level for each bad entry;
- the large-page address merging;
- the full permission matrix over loads, stores and fetches;
- that write-back is skipped when the referenced and modified bits are already set.

// File: rtl/mmu_walk_pkg.sv
package mmu_walk_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 36;
  localparam int ENT_W     = 32;
  localparam int CTX_W     = 4;
  localparam int OFF_W     = 12;
  localparam int IDX1_W    = 8;
  localparam int IDX23_W   = 6;
  localparam int LVL_W     = 2;
  localparam int FAULT_W   = 3;
  localparam int BASE_SH   = PA_W - ENT_W + 2;
  localparam int BIT_CACHE = 7;
  localparam int BIT_MOD   = 6;
  localparam int BIT_REF   = 5;

  typedef enum logic [1:0] {ET_INVALID = 2'd0, ET_PTD = 2'd1, ET_PTE = 2'd2, ET_RSVD = 2'd3} etype_e;
  typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2, ACC_OTHER = 2'd3} acc_e;

  localparam logic [FAULT_W-1:0] FLT_NONE = 3'd0;
  localparam logic [FAULT_W-1:0] FLT_PROT = 3'd5;

  // Rights matrix for the 3-bit access code (R7, R8)
  function automatic logic perm_ok(input logic [2:0] code, input logic user, input acc_e acc);
    logic rd, wr, ex;
    if (user) begin
      rd = (code inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd5});
      wr = (code inside {3'd1, 3'd3});
      ex = (code inside {3'd2, 3'd3, 3'd4});
    end else begin
      rd = (code != 3'd4);
      wr = (code inside {3'd1, 3'd3, 3'd5, 3'd7});
      ex = (code inside {3'd2, 3'd3, 3'd4, 3'd6, 3'd7});
    end
    case (acc)
      ACC_STORE: perm_ok = wr;
      ACC_FETCH: perm_ok = ex;
      default:   perm_ok = rd;
    endcase
  endfunction
endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
  import mmu_walk_pkg::*;
(
  input  logic [ENT_W-1:0] ctp,
  input  logic [CTX_W-1:0] ctx,
  input  logic [ENT_W-1:0] desc,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] child_lvl,
  output logic [PA_W-1:0]  ctx_addr,
  output logic [PA_W-1:0]  child_addr
);
  localparam int IDX_MAX = IDX1_W;

  logic [IDX_MAX-1:0] idx;
  logic [PA_W-1:0]    ctx_base, child_base;

  // Region, segment and page index fields (R2)
  always_comb begin
    case (child_lvl)
      2'd1:    idx = va[VA_W-1 -: IDX1_W];
      2'd2:    idx = IDX_MAX'(va[VA_W-IDX1_W-1 -: IDX23_W]);
      default: idx = IDX_MAX'(va[OFF_W+IDX23_W-1 -: IDX23_W]);
    endcase
  end

  assign ctx_base   = {ctp[ENT_W-1:2], {BASE_SH{1'b0}}};
  assign child_base = {desc[ENT_W-1:2], {BASE_SH{1'b0}}};
  assign ctx_addr   = ctx_base + (PA_W'(ctx) << 2);
  assign child_addr = child_base + (PA_W'(idx) << 2);

  logic unused_bits;
  assign unused_bits = ^{ctp[1:0], desc[1:0], va[OFF_W-1:0]};
endmodule

// File: rtl/walk_pte_eval.sv
module walk_pte_eval
  import mmu_walk_pkg::*;
(
  input  logic [ENT_W-1:0] pte,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  va,
  input  acc_e             acc,
  input  logic             user,
  output logic             ok,
  output logic             need_wb,
  output logic [ENT_W-1:0] new_pte,
  output logic [PA_W-1:0]  pa,
  output logic             cacheable
);
  localparam int OFF_L1 = OFF_W + 2 * IDX23_W;
  localparam int OFF_L2 = OFF_W + IDX23_W;

  logic [PA_W-1:0] keep_mask;
  logic [PA_W-1:0] frame;

  // Large-page offset widths per level (R5)
  always_comb begin
    case (lvl)
      2'd1:    keep_mask = (PA_W'(1) << OFF_L1) - PA_W'(1);
      2'd2:    keep_mask = (PA_W'(1) << OFF_L2) - PA_W'(1);
      default: keep_mask = (PA_W'(1) << OFF_W) - PA_W'(1);
    endcase
  end

  assign frame     = {pte[ENT_W-1:8], {OFF_W{1'b0}}};
  assign pa        = (frame & ~keep_mask) | (PA_W'(va) & keep_mask);
  assign cacheable = pte[BIT_CACHE];
  assign ok        = perm_ok(pte[4:2], user, acc);
  assign new_pte   = pte | (ENT_W'(1) << BIT_REF)
                   | ((acc == ACC_STORE) ? (ENT_W'(1) << BIT_MOD) : '0);
  assign need_wb   = (new_pte != pte);

  logic unused_bits;
  assign unused_bits = ^pte[1:0];
endmodule

// File: rtl/mmu_tablewalk.sv
module mmu_tablewalk
  import mmu_walk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_va,
  input  logic [CTX_W-1:0]   req_ctx,
  input  logic [ENT_W-1:0]   req_ctp,
  input  logic [1:0]         req_acc,
  input  logic               req_user,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [ENT_W-1:0]   mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ENT_W-1:0]   mem_rsp_data,
  output logic               res_valid,
  output logic [PA_W-1:0]    res_pa,
  output logic               res_cacheable,
  output logic [FAULT_W-1:0] res_fault
);
  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_WB_REQ, S_WB_WAIT} st_e;

  st_e              st;
  logic [LVL_W-1:0] lvl, lvl_nxt;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  logic             user_q;
  logic [PA_W-1:0]  addr_q;
  logic [ENT_W-1:0] wdata_q;

  logic [PA_W-1:0]  ctx_addr, child_addr, pte_pa;
  logic             pte_ok, pte_wb, pte_cache;
  logic [ENT_W-1:0] pte_new;
  etype_e           rsp_type;

  assign lvl_nxt  = lvl + 2'd1;
  assign rsp_type = etype_e'(mem_rsp_data[1:0]);

  walk_addr_gen i_addr (
    .ctp(req_ctp), .ctx(req_ctx), .desc(mem_rsp_data), .va(va_q),
    .child_lvl(lvl_nxt), .ctx_addr(ctx_addr), .child_addr(child_addr)
  );

  walk_pte_eval i_eval (
    .pte(mem_rsp_data), .lvl(lvl), .va(va_q), .acc(acc_q), .user(user_q),
    .ok(pte_ok), .need_wb(pte_wb), .new_pte(pte_new), .pa(pte_pa), .cacheable(pte_cache)
  );

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD_REQ) || (st == S_WB_REQ);
  assign mem_req_write = (st == S_WB_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; lvl <= '0; va_q <= '0; acc_q <= ACC_LOAD; user_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0;
      res_valid <= 1'b0; res_pa <= '0; res_cacheable <= 1'b0; res_fault <= FLT_NONE;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q <= req_va; acc_q <= acc_e'(req_acc); user_q <= req_user;
          lvl <= '0; addr_q <= ctx_addr; st <= S_RD_REQ;
        end
        S_RD_REQ: if (mem_req_ready) st <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) begin
          if (rsp_type == ET_PTD && lvl != 2'd3) begin
            addr_q <= child_addr; lvl <= lvl_nxt; st <= S_RD_REQ;
          end else if (rsp_type == ET_PTE && lvl != 2'd0 && pte_ok) begin
            res_pa <= pte_pa; res_cacheable <= pte_cache; res_fault <= FLT_NONE;
            if (pte_wb) begin
              wdata_q <= pte_new; st <= S_WB_REQ;
            end else begin
              res_valid <= 1'b1; st <= S_IDLE;
            end
          end else begin
            res_valid <= 1'b1; res_pa <= '0; res_cacheable <= 1'b0; st <= S_IDLE;
            res_fault <= (rsp_type == ET_PTE && lvl != 2'd0) ? FLT_PROT
                                                            : FAULT_W'(lvl) + 3'd1;
          end
        end
        S_WB_REQ: if (mem_req_ready) st <= S_WB_WAIT;
        S_WB_WAIT: if (mem_rsp_valid) begin
          res_valid <= 1'b1; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Assertion-side tracker of the in-flight memory transaction
  logic outst_q;
  always_ff @(posedge clk) begin
    if (rst) outst_q <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
    else if (mem_rsp_valid) outst_q <= 1'b0;
  end

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !outst_q);

  p_wb_ref_set_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> (mem_req_wdata[BIT_REF] && mem_req_wdata[1:0] == 2'd2));

  p_fault_clean_r10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault != FLT_NONE) |-> (res_pa == '0 && !res_cacheable));

  p_user_high_code_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD_WAIT && mem_rsp_valid && mem_rsp_data[1:0] == 2'd2 && lvl != 2'd0
      && user_q && mem_rsp_data[4:2] > 3'd5) |=> (res_valid && res_fault == FLT_PROT));

  p_res_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);
endmodule

// File: tb/test_mmu_tablewalk.sv
`timescale 1ns/1ps
module test_mmu_tablewalk;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_user;
  logic [31:0] req_va, req_ctp;
  logic [3:0]  req_ctx;
  logic [1:0]  req_acc;
  logic        mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_req_wdata, mem_rsp_data;
  logic        res_valid, res_cacheable;
  logic [35:0] res_pa;
  logic [2:0]  res_fault;

  mmu_tablewalk i_mmu_tablewalk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_ctx(req_ctx), .req_ctp(req_ctp), .req_acc(req_acc), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_pa(res_pa),
    .res_cacheable(res_cacheable), .res_fault(res_fault)
  );

  initial forever #2 clk = ~clk;

  int n_checks = 0, n_err = 0, wr_count = 0;
  logic [31:0] mem_m [logic [35:0]];
  logic [35:0] exp_pa_q[$];
  logic        exp_c_q[$];
  logic [2:0]  exp_f_q[$];
  string       exp_tag_q[$];

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;
  localparam logic [31:0] CTP = 32'h0000_0100;       // context table at 0x1000
  localparam logic [35:0] RT = 36'h2000, ST_T = 36'h3000, PT = 36'h4000, PT2 = 36'h4100;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [35:0] a);
    return mem_m.exists(a) ? mem_m[a] : 32'h0;
  endfunction
  function automatic logic [31:0] ptd(input logic [35:0] base);
    return base[35:4] | 32'h1;
  endfunction
  function automatic logic [31:0] mk_pte(input logic [23:0] ppn, input logic c, m, r,
                                         input logic [2:0] code);
    return {ppn, c, m, r, code, 2'b10};
  endfunction
  function automatic logic [31:0] mkva(input logic [7:0] r, input logic [5:0] s,
                                       input logic [5:0] p, input logic [11:0] off);
    return {r, s, p, off};
  endfunction

  // Memory model: one transaction at a time, periodic back-pressure
  initial begin : memory_model
    logic        pend;
    logic [31:0] dat;
    int          ncyc;
    logic        rdy;
    pend = 1'b0; dat = '0; ncyc = 0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = pend;
      mem_rsp_data  = pend ? dat : 32'h0;
      pend = 1'b0;
      rdy = (ncyc % 3) != 1;
      ncyc++;
      mem_req_ready = rdy;
      if (mem_req_valid === 1'b1 && rdy) begin
        if (mem_req_write) begin
          mem_m[mem_req_addr] = mem_req_wdata; wr_count++; dat = '0;
        end else dat = rd(mem_req_addr);
        pend = 1'b1;
      end
    end
  end

  // Scoreboard monitor
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (res_valid === 1'b1) begin
        if (exp_pa_q.size() == 0) begin
          n_checks++; n_err++;
          $display("FAIL R12: actual unexpected result expected none");
        end else begin
          string t;
          t = exp_tag_q.pop_front();
          chk({t, " pa"}, 64'(res_pa), 64'(exp_pa_q.pop_front()));
          chk({t, " cacheable"}, 64'(res_cacheable), 64'(exp_c_q.pop_front()));
          chk({t, " fault"}, 64'(res_fault), 64'(exp_f_q.pop_front()));
        end
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [3:0] ctx, input logic [1:0] acc,
                      input logic user, input logic [35:0] epa, input logic ec,
                      input logic [2:0] ef, input string tag);
    exp_pa_q.push_back(epa); exp_c_q.push_back(ec); exp_f_q.push_back(ef); exp_tag_q.push_back(tag);
    @(negedge clk);
    while (req_ready !== 1'b1) @(negedge clk);
    req_va = va; req_ctx = ctx; req_acc = acc; req_user = user; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_pa_q.size() != 0) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL R12: actual walk hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin : main
    logic [31:0] va, p;
    int          w0;
    rst = 1'b1; req_valid = 1'b0; req_va = '0; req_ctx = '0; req_ctp = CTP;
    req_acc = LD; req_user = 1'b0;
    // table image
    mem_m[36'h100C] = ptd(RT);                         // ctx 3
    mem_m[36'h1014] = 32'h0;                           // ctx 5 invalid
    mem_m[36'h1018] = mk_pte(24'h1, 1, 0, 1, 3'd3);    // ctx 6 PTE at context level
    mem_m[RT + 4*8'h12] = ptd(ST_T);
    mem_m[RT + 4*8'h13] = 32'h0;
    mem_m[RT + 4*8'h40] = mk_pte(24'hABCDEF, 1, 0, 1, 3'd3);
    mem_m[ST_T + 4*6'h0D] = ptd(PT);
    mem_m[ST_T + 4*6'h01] = 32'h3;
    mem_m[ST_T + 4*6'h02] = mk_pte(24'h5A5A5A, 0, 0, 0, 3'd1);
    mem_m[ST_T + 4*6'h03] = ptd(PT2);
    mem_m[PT2 + 0] = ptd(36'h5000);
    mem_m[PT2 + 4] = 32'h0;
    mem_m[PT + 4*0] = mk_pte(24'h000A11, 1, 0, 0, 3'd1);
    mem_m[PT + 4*1] = mk_pte(24'h00BEEF, 0, 1, 1, 3'd5);
    mem_m[PT + 4*2] = mk_pte(24'h000222, 1, 0, 1, 3'd6);
    mem_m[PT + 4*3] = mk_pte(24'h000333, 1, 0, 1, 3'd4);
    mem_m[PT + 4*4] = mk_pte(24'h000444, 1, 0, 1, 3'd7);
    mem_m[PT + 4*5] = mk_pte(24'h000555, 1, 0, 0, 3'd0);
    mem_m[PT + 4*6] = mk_pte(24'h000666, 1, 0, 1, 3'd2);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 res_valid", 64'(res_valid), 64'd0);
    chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);

    // R2 R5 R6 R9: page-level hit, referenced bit written back
    va = mkva(8'h12, 6'h0D, 6'd0, 12'h678); p = mk_pte(24'h000A11, 1, 0, 0, 3'd1);
    w0 = wr_count;
    walk(va, 4'd3, LD, 0, {24'h000A11, 12'h678}, 1'b1, 3'd0, "R5 page load");
    chk("R9 ref write", 64'(rd(PT)), 64'(p | 32'h20));
    chk("R9 one write", 64'(wr_count - w0), 64'd1);
    w0 = wr_count;
    walk(va, 4'd3, LD, 0, {24'h000A11, 12'h678}, 1'b1, 3'd0, "R9 reload");
    chk("R9 no rewrite", 64'(wr_count - w0), 64'd0);
    walk(va, 4'd3, ST, 0, {24'h000A11, 12'h678}, 1'b1, 3'd0, "R9 store");
    chk("R9 mod write", 64'(rd(PT)), 64'(p | 32'h60));

    // R7 R10: user store on code 5 denied, entry untouched
    va = mkva(8'h12, 6'h0D, 6'd1, 12'h001); p = mk_pte(24'h00BEEF, 0, 1, 1, 3'd5);
    w0 = wr_count;
    walk(va, 4'd3, ST, 1, 36'h0, 1'b0, 3'd5, "R7 user store code5");
    chk("R10 no write on fault", 64'(wr_count - w0), 64'd0);
    walk(va, 4'd3, LD, 1, {24'h00BEEF, 12'h001}, 1'b0, 3'd0, "R6 user load uncached");
    walk(va, 4'd3, ST, 0, {24'h00BEEF, 12'h001}, 1'b0, 3'd0, "R8 sup store code5");
    chk("R9 already set", 64'(rd(PT + 4)), 64'(p));

    va = mkva(8'h12, 6'h0D, 6'd2, 12'hFFF);
    walk(va, 4'd3, LD, 1, 36'h0, 1'b0, 3'd5, "R7 user load code6");
    walk(va, 4'd3, LD, 0, {24'h000222, 12'hFFF}, 1'b1, 3'd0, "R8 sup load code6");
    walk(va, 4'd3, FE, 0, {24'h000222, 12'hFFF}, 1'b1, 3'd0, "R8 sup fetch code6");
    walk(va, 4'd3, ST, 0, 36'h0, 1'b0, 3'd5, "R8 sup store code6");

    va = mkva(8'h12, 6'h0D, 6'd3, 12'h010);
    walk(va, 4'd3, FE, 1, {24'h000333, 12'h010}, 1'b1, 3'd0, "R7 user fetch code4");
    walk(va, 4'd3, LD, 1, 36'h0, 1'b0, 3'd5, "R7 user load code4");
    walk(va, 4'd3, LD, 0, 36'h0, 1'b0, 3'd5, "R8 sup load code4");

    va = mkva(8'h12, 6'h0D, 6'd4, 12'h020); p = mk_pte(24'h000444, 1, 0, 1, 3'd7);
    walk(va, 4'd3, FE, 1, 36'h0, 1'b0, 3'd5, "R7 user fetch code7");
    walk(va, 4'd3, ST, 0, {24'h000444, 12'h020}, 1'b1, 3'd0, "R8 sup store code7");
    chk("R9 mod only", 64'(rd(PT + 16)), 64'(p | 32'h40));

    va = mkva(8'h12, 6'h0D, 6'd5, 12'h030); p = mk_pte(24'h000555, 1, 0, 0, 3'd0);
    walk(va, 4'd3, ST, 0, 36'h0, 1'b0, 3'd5, "R8 sup store code0");
    chk("R10 entry unchanged", 64'(rd(PT + 20)), 64'(p));

    va = mkva(8'h12, 6'h0D, 6'd6, 12'h040);
    walk(va, 4'd3, FE, 1, {24'h000666, 12'h040}, 1'b1, 3'd0, "R7 user fetch code2");
    walk(va, 4'd3, ST, 1, 36'h0, 1'b0, 3'd5, "R7 user store code2");

    // R3 R4: bad entries at each level
    walk(mkva(8'h12, 6'h0D, 6'd0, 12'h0), 4'd5, LD, 0, 36'h0, 1'b0, 3'd1, "R3 ctx invalid");
    walk(mkva(8'h12, 6'h0D, 6'd0, 12'h0), 4'd6, LD, 0, 36'h0, 1'b0, 3'd1, "R4 ctx pte");
    walk(mkva(8'h13, 6'h00, 6'd0, 12'h0), 4'd3, LD, 0, 36'h0, 1'b0, 3'd2, "R3 region invalid");
    walk(mkva(8'h12, 6'h01, 6'd0, 12'h0), 4'd3, LD, 0, 36'h0, 1'b0, 3'd3, "R3 segment reserved");
    walk(mkva(8'h12, 6'h03, 6'd0, 12'h0), 4'd3, LD, 0, 36'h0, 1'b0, 3'd4, "R4 page descriptor");
    walk(mkva(8'h12, 6'h03, 6'd1, 12'h0), 4'd3, LD, 0, 36'h0, 1'b0, 3'd4, "R3 page invalid");

    // R5: large pages at region and segment level
    va = mkva(8'h40, 6'h2B, 6'd17, 12'h9AB);
    walk(va, 4'd3, LD, 0, {12'hABC, va[23:0]}, 1'b1, 3'd0, "R5 region page");
    va = mkva(8'h12, 6'h02, 6'd33, 12'h456); p = mk_pte(24'h5A5A5A, 0, 0, 0, 3'd1);
    walk(va, 4'd3, LD, 1, {18'h16969, va[17:0]}, 1'b0, 3'd0, "R5 segment page");
    chk("R9 segment write-back", 64'(rd(ST_T + 8)), 64'(p | 32'h20));

    repeat (4) @(negedge clk);
    chk("R12 idle after walks", 64'(req_ready), 64'd1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule